// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem-status part of a UART-style serial port. It watches four active-low handshake inputs from a modem or peer device: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input passes through a multi-flop synchroniser. The block then shows the current asserted level of each input in the upper nibble of an 8-bit status word. In the lower nibble it latches a sticky flag whenever an input changes. Any pending flag raises an interrupt request, provided the interrupt enable is high.

A host read is a single-cycle strobe. The status word is always visible on the read-data port. In the strobe cycle the port shows the flags as they were, and the flags clear on the following edge. In loopback mode the four status levels are taken from the control-register outputs instead of the pins, and the change logic runs on those sourced levels. This lets software exercise the whole path without a cable. The block has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `modem_status_monitor`

## Requirements
- R1: After reset the read-data port is 0x00 (pins held high, loopback off) and `irq_o` is low.
- R2: Outside loopback, bits 7..4 are the inverted synchronised pins, in the order carrier detect (7), ring (6), data-set-ready (5), clear-to-send (4). A pin change is visible on the port two clock edges after it is applied.
- R3: Bits 0 (clear-to-send), 1 (data-set-ready) and 3 (carrier detect) set on the edge after the corresponding status bit changes, in either direction.
- R4: Bit 2 (ring) sets only when the ring pin goes from 0 to 1, which makes status bit 6 fall. A 1-to-0 change on the ring pin leaves bit 2 unchanged.
- R5: A cycle with `rd_stb_i` high clears bits 3..0 on the next edge.
- R6: If a change is detected in the same cycle as a read, the port shows the flag's previous value during that read, and the flag is 1 after it.
- R7: In loopback, bit 4 follows `ctl_rts_i`, bit 5 follows `ctl_dtr_i`, bit 6 follows `ctl_aux1_i` and bit 7 follows `ctl_aux2_i` in the same cycle. Pin activity has no effect on the port.
- R8: In loopback, changes on the control inputs set the flags under the same rules as R3 and R4. For the ring flag, that rule means a 1-to-0 change on `ctl_aux1_i`.
- R9: Entering or leaving loopback sets no flag, even when the pin levels and control levels differ.
- R10: `irq_o` is high exactly when `irq_en_i` is high and at least one of bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| pin_ring_n | input | 1 | Ring indicator pin, active low, asynchronous |
| pin_cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| rd_stb_i | input | 1 | One-cycle host read of the status word |
| loop_en_i | input | 1 | Loopback mode select |
| ctl_dtr_i | input | 1 | Control-register DTR bit |
| ctl_rts_i | input | 1 | Control-register RTS bit |
| ctl_aux1_i | input | 1 | Control-register auxiliary output 1 |
| ctl_aux2_i | input | 1 | Control-register auxiliary output 2 |
| irq_en_i | input | 1 | Modem-status interrupt enable |
| rd_data_o | output | 8 | Status word: levels in 7..4, change flags in 3..0 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the control inputs, the loopback select and the read strobe are synchronous to `clk`, and that only the four pins are asynchronous. They also assume that the pins rest high during reset, so the synchroniser's reset value matches the pins. The stimulus drives every input shortly after a rising edge and keeps the pins high while reset is applied. The mode switches are placed at moments when the pin levels and the control levels differ, so that R9 is tested rather than trivially met.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int unsigned CH_N = 4;
  localparam int unsigned CH_CTS  = 0;
  localparam int unsigned CH_DSR  = 1;
  localparam int unsigned CH_RING = 2;
  localparam int unsigned CH_CD   = 3;
  localparam int unsigned WORD_W  = 2 * CH_N;
  typedef logic [CH_N-1:0] ch_vec_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= din;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mstat_route.sv
module mstat_route
  import mstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    loop_en,
  input  ch_vec_t ctl_lvl,
  input  ch_vec_t pin_sync_n,
  output ch_vec_t lvl,
  output logic    mode_chg
);
  logic loop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loop_q <= 1'b0;
    else        loop_q <= loop_en;
  end

  assign mode_chg = loop_en ^ loop_q;
  assign lvl      = loop_en ? ctl_lvl : ~pin_sync_n;
endmodule

// File: rtl/mstat_detect.sv
module mstat_detect #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TRAIL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         mode_chg,
  input  logic         rd_stb,
  output logic [W-1:0] hit,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_ch
    if (TRAIL_MASK[i]) begin : g_trail
      assign hit[i] = lvl_q[i] & ~lvl[i] & ~mode_chg;
    end else begin : g_any
      assign hit[i] = (lvl_q[i] ^ lvl[i]) & ~mode_chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= (flag_q[i] & ~rd_stb) | hit[i];
    end

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !hit[i]) |=> !flag_q[i]);
    p_hit_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flag_q[i]);
    p_switch_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && !flag_q[i]) |=> !flag_q[i]);
    if (TRAIL_MASK[i]) begin : g_chk_trail
      p_ring_lead_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_q[i] && lvl[i] && !flag_q[i]) |=> !flag_q[i]);
    end
  end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
  import mstat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts_n,
  input  logic       pin_dsr_n,
  input  logic       pin_ring_n,
  input  logic       pin_cd_n,
  input  logic       rd_stb_i,
  input  logic       loop_en_i,
  input  logic       ctl_dtr_i,
  input  logic       ctl_rts_i,
  input  logic       ctl_aux1_i,
  input  logic       ctl_aux2_i,
  input  logic       irq_en_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  localparam ch_vec_t TRAIL = ch_vec_t'(1) << CH_RING;

  ch_vec_t pin_raw_n, pin_sync_n, ctl_lvl, lvl, hit, flag_q;
  logic    mode_chg;

  always_comb begin
    pin_raw_n          = '1;
    pin_raw_n[CH_CTS]  = pin_cts_n;
    pin_raw_n[CH_DSR]  = pin_dsr_n;
    pin_raw_n[CH_RING] = pin_ring_n;
    pin_raw_n[CH_CD]   = pin_cd_n;
    ctl_lvl            = '0;
    ctl_lvl[CH_CTS]    = ctl_rts_i;
    ctl_lvl[CH_DSR]    = ctl_dtr_i;
    ctl_lvl[CH_RING]   = ctl_aux1_i;
    ctl_lvl[CH_CD]     = ctl_aux2_i;
  end

  mstat_sync #(.W(CH_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_raw_n), .dout(pin_sync_n));

  mstat_route u_route (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en_i), .ctl_lvl(ctl_lvl),
    .pin_sync_n(pin_sync_n), .lvl(lvl), .mode_chg(mode_chg));

  mstat_detect #(.W(CH_N), .TRAIL_MASK(TRAIL)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .mode_chg(mode_chg),
    .rd_stb(rd_stb_i), .hit(hit), .flag_q(flag_q));

  assign rd_data_o = {lvl, flag_q};
  assign irq_o     = irq_en_i & (|flag_q);

  p_irq_follows_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit && irq_en_i) |=> (!irq_en_i || irq_o));
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !(|hit)) |=> !irq_o);
endmodule

// File: tb/modem_status_monitor_tb_top.sv
module modem_status_monitor_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1, dsr_n = 1, ring_n = 1, cd_n = 1;
  logic rd = 0, loop_en = 0, dtr = 0, rts = 0, aux1 = 0, aux2 = 0, irq_en = 0;
  logic [7:0] rd_data;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_status_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .pin_cts_n(cts_n), .pin_dsr_n(dsr_n),
    .pin_ring_n(ring_n), .pin_cd_n(cd_n), .rd_stb_i(rd), .loop_en_i(loop_en),
    .ctl_dtr_i(dtr), .ctl_rts_i(rts), .ctl_aux1_i(aux1), .ctl_aux2_i(aux2),
    .irq_en_i(irq_en), .rd_data_o(rd_data), .irq_o(irq));

  // reference model state
  logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prev = 0, m_flag = 0;
  logic m_loop = 0;

  function automatic logic [3:0] m_lvl();
    return loop_en ? {aux2, aux1, dtr, rts} : ~m_s2;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 4'hF; m_s2 = 4'hF; m_prev = 0; m_flag = 0; m_loop = 0;
    end else begin
      logic [3:0] lv;
      logic chg;
      lv  = m_lvl();
      chg = (loop_en != m_loop);
      for (int i = 0; i < 4; i++) begin
        logic h;
        h = chg ? 1'b0 : (i == 2) ? (m_prev[i] & ~lv[i]) : (m_prev[i] ^ lv[i]);
        m_flag[i] = (m_flag[i] & ~rd) | h;
      end
      m_prev = lv;
      m_loop = loop_en;
      m_s2 = m_s1;
      m_s1 = {cd_n, ring_n, dsr_n, cts_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(loop_en ? "R7 levels" : "R2 levels", rd_data[7:4], m_lvl());
      chk("R3 flag cts", rd_data[0], m_flag[0]);
      chk("R3 flag dsr", rd_data[1], m_flag[1]);
      chk("R4 flag ring", rd_data[2], m_flag[2]);
      chk("R3 flag cd", rd_data[3], m_flag[3]);
      chk("R10 irq", irq, irq_en & (|m_flag));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_read();
    rd = 1; step(1); rd = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", rd_data, 8'h00);
    chk("R1 reset irq", irq, 0);
    step(1);
    irq_en = 1;
    cts_n = 0; step(1);
    @(negedge clk); chk("R2 not yet visible", rd_data[4], 0);
    step(1);
    @(negedge clk); chk("R2 visible after two edges", rd_data[4], 1);
    step(1);
    @(negedge clk); chk("R3 cts falling pin flag", rd_data[0], 1);
    chk("R10 irq raised", irq, 1);
    step(1); do_read();
    @(negedge clk); chk("R5 cleared", rd_data[3:0], 0);
    chk("R10 irq dropped", irq, 0);
    cts_n = 1; step(4);
    @(negedge clk); chk("R3 cts rising pin flag", rd_data[0], 1);
    do_read();
    ring_n = 0; step(4);
    @(negedge clk); chk("R4 ring falling ignored", rd_data[2], 0);
    chk("R2 ring level", rd_data[6], 1);
    ring_n = 1; step(4);
    @(negedge clk); chk("R4 ring trailing edge flag", rd_data[2], 1);
    do_read();
    dsr_n = 0; step(4); dsr_n = 1; step(4);
    @(negedge clk); chk("R3 dsr flag", rd_data[1], 1);
    do_read();
    // R6: flag already set, new edge in read cycle
    cd_n = 0; step(4);
    cd_n = 1; step(2);
    rd = 1;
    @(negedge clk); chk("R6 read shows old flag", rd_data[3], 1);
    step(1); rd = 0;
    @(negedge clk); chk("R6 flag survives read", rd_data[3], 1);
    do_read();
    @(negedge clk); chk("R5 cleared again", rd_data[3:0], 0);
    // R9 entering loopback with mismatched levels
    cts_n = 0; cd_n = 0; step(4); do_read();
    loop_en = 1; step(1);
    @(negedge clk); chk("R7 loop levels", rd_data[7:4], 4'h0);
    step(1);
    @(negedge clk); chk("R9 entry no flag", rd_data[3:0], 0);
    rts = 1;
    @(negedge clk); chk("R7 rts same cycle", rd_data[4], 1);
    step(1);
    @(negedge clk); chk("R8 rts flag", rd_data[0], 1);
    do_read();
    cts_n = 1; dsr_n = 0; ring_n = 0; step(4);
    @(negedge clk); chk("R7 pins ignored", rd_data, {4'b0001, 4'b0000});
    aux1 = 1; step(2);
    @(negedge clk); chk("R8 aux1 rise no ring flag", rd_data[2], 0);
    aux1 = 0; step(1);
    @(negedge clk); chk("R8 aux1 fall ring flag", rd_data[2], 1);
    dtr = 1; aux2 = 1; step(1);
    @(negedge clk); chk("R8 dtr aux2 flags", {rd_data[3], rd_data[1]}, 2'b11);
    do_read();
    loop_en = 0; step(2);
    @(negedge clk); chk("R9 exit no flag", rd_data[3:0], 0);
    chk("R2 pins back", rd_data[7:4], 4'b1110);
    irq_en = 0; dsr_n = 1; step(4);
    @(negedge clk); chk("R10 masked irq", irq, 0);
    chk("R3 dsr flag while masked", rd_data[1], 1);
    irq_en = 1; step(1);
    @(negedge clk); chk("R10 unmasked irq", irq, 1);
    do_read(); step(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule